// File: doc/BRIEF.md
# Outbound Window Translator

This block maps local-bus memory addresses that fall in an outbound region onto 64-bit link-side bus addresses. The region above a fixed base is cut into a bank of equal windows. One programmable size field sets the window span as a power-of-two number of megabytes. The window a lookup lands in is the local address minus the base, shifted right by log2 of the window span.

Each window has two 32-bit offset registers: a low word, whose bit 0 marks the window usable, and a high word. A hit returns the high word and the low word, with bit 0 cleared, joined into a 64-bit base. The address bits below the window span are added to that base. A global translate-enable bit gates every lookup.

Software programs the block through a simple word register port with one-cycle read latency. The datapath presents one address per cycle and gets a registered result one cycle later.

Top module: `oat_xlate`

## Requirements
- R1: After reset every register reads as zero, and every lookup returns no hit with a zero address.
- R2: Register map (byte offsets, word aligned). 0x004 is the control word; only bit 1, the global translate enable, is stored and read back, and other bits read 0. 0x030 holds the 3-bit size code in bits 2:0. 0x200 + 8n is the low offset of window n and 0x204 + 8n its high offset, both full 32 bits. Read data appears on the cycle after the read strobe and is zero otherwise.
- R3: The window span is 2^(20+size) bytes. A lookup uses window index (addr − base) >> (20+size).
- R4: On a hit the result is {high offset, low offset with bit 0 cleared} + ((addr − base) mod span), as a 64-bit value.
- R5: Every lookup strobe gives exactly one result-valid pulse on the next cycle. A write and a lookup in the same cycle translate with the register values from before the write.
- R6: A lookup that lands in a window whose low-offset bit 0 is 0 gives result-valid with no hit and a zero address.
- R7: While the global enable is 0, no lookup hits.
- R8: An address below the base, or one whose window index is at or above the window count (32), gives no hit.
- R9: Writes to offsets outside the map, or to offsets that are not word aligned, change no register. Reads of them return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after reg_rd |
| lk_valid | input | 1 | Lookup strobe |
| lk_addr | input | 32 | Local address to translate |
| res_valid | output | 1 | Result strobe, one cycle after lk_valid |
| res_hit | output | 1 | Translation succeeded |
| res_addr | output | 64 | Translated address, zero on a miss |

## Verification
Lookups are swept at the smallest, a middle and the largest size code. This separates a correct shift amount from a fixed one, and a correct offset mask from a full-address pass-through. Addresses placed at the first and last window, one window past the end, and just below the base show whether range limits are enforced. A disabled window placed between enabled ones, and runs with the global enable cleared, separate the per-window gate from the global gate. A register write issued in the same cycle as a lookup shows whether translation reads the old or the new register values.

// File: rtl/oat_pkg.sv
package oat_pkg;

   localparam int unsigned CTRL_OFS      = 32'h004;
   localparam int unsigned SIZE_OFS      = 32'h030;
   localparam int unsigned WIN_OFS       = 32'h200;
   localparam int unsigned WIN_STRIDE    = 8;
   localparam int unsigned XLAT_EN_BIT   = 1;
   localparam int unsigned WIN_VALID_BIT = 0;

   typedef enum logic [2:0] {
      RK_NONE,
      RK_CTRL,
      RK_SIZE,
      RK_WLO,
      RK_WHI
   } reg_kind_e;

endpackage

// File: rtl/oat_regs.sv
module oat_regs
   import oat_pkg::*;
#(
   parameter int NUM_WIN = 32,
   parameter int DATA_W  = 32,
   parameter int REG_AW  = 12,
   parameter int SIZE_W  = 3,
   localparam int IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic                           rd_en,
   input  logic [REG_AW-1:0]              reg_addr,
   input  logic [DATA_W-1:0]              wdata,
   output logic [DATA_W-1:0]              rdata,
   output logic                           xlat_en,
   output logic [SIZE_W-1:0]              win_size,
   output logic [NUM_WIN-1:0][DATA_W-1:0] win_lo,
   output logic [NUM_WIN-1:0][DATA_W-1:0] win_hi
);

   localparam int unsigned WIN_SPAN = WIN_STRIDE * NUM_WIN;

   reg_kind_e         kind;
   logic [IDX_W-1:0]  widx;
   logic [31:0]       a32;
   logic [31:0]       rel32;

   always_comb begin
      a32   = 32'(reg_addr);
      rel32 = a32 - WIN_OFS;
      kind  = RK_NONE;
      widx  = '0;
      if (a32[1:0] == 2'b00) begin
         if (a32 == CTRL_OFS) begin
            kind = RK_CTRL;
         end else if (a32 == SIZE_OFS) begin
            kind = RK_SIZE;
         end else if (a32 >= WIN_OFS && rel32 < WIN_SPAN) begin
            widx = rel32[3 +: IDX_W];
            kind = rel32[2] ? RK_WHI : RK_WLO;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xlat_en  <= 1'b0;
         win_size <= '0;
      end else if (wr_en) begin
         if (kind == RK_CTRL) xlat_en  <= wdata[XLAT_EN_BIT];
         if (kind == RK_SIZE) win_size <= wdata[SIZE_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_lo <= '0;
         win_hi <= '0;
      end else if (wr_en) begin
         for (int w = 0; w < NUM_WIN; w++) begin
            if (widx == IDX_W'(w)) begin
               if (kind == RK_WLO) win_lo[w] <= wdata;
               if (kind == RK_WHI) win_hi[w] <= wdata;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
      end else begin
         rdata <= '0;
         if (rd_en) begin
            case (kind)
               RK_CTRL: rdata[XLAT_EN_BIT] <= xlat_en;
               RK_SIZE: rdata[SIZE_W-1:0]  <= win_size;
               RK_WLO:  rdata <= win_lo[widx];
               RK_WHI:  rdata <= win_hi[widx];
               default: rdata <= '0;
            endcase
         end
      end
   end

   // R2
   size_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && 32'(reg_addr) == SIZE_OFS) |=> win_size == $past(wdata[SIZE_W-1:0]));

   // R2
   size_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && 32'(reg_addr) == SIZE_OFS) |=> rdata == DATA_W'($past(win_size)));

   // R9
   unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && kind == RK_NONE) |=> ($stable(win_size) && $stable(xlat_en)
                                      && $stable(win_lo) && $stable(win_hi)));

   // R2
   idle_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> rdata == '0);

endmodule

// File: rtl/oat_lookup.sv
module oat_lookup
   import oat_pkg::*;
#(
   parameter int NUM_WIN             = 32,
   parameter int ADDR_W              = 32,
   parameter int DATA_W              = 32,
   parameter int SIZE_W              = 3,
   parameter int MB_SHIFT            = 20,
   parameter logic [ADDR_W-1:0] BASE = '0,
   localparam int IDX_W              = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
   localparam int OUT_W              = 2 * DATA_W,
   localparam int SH_W               = $clog2(ADDR_W) + 1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           lk_valid,
   input  logic [ADDR_W-1:0]              lk_addr,
   input  logic                           xlat_en,
   input  logic [SIZE_W-1:0]              win_size,
   input  logic [NUM_WIN-1:0][DATA_W-1:0] win_lo,
   input  logic [NUM_WIN-1:0][DATA_W-1:0] win_hi,
   output logic                           res_valid,
   output logic                           res_hit,
   output logic [OUT_W-1:0]               res_addr
);

   logic              below;
   logic [ADDR_W-1:0] rel;
   logic [SH_W-1:0]   shamt;
   logic [ADDR_W-1:0] win_full;
   logic              in_rng;
   logic [IDX_W-1:0]  idx;
   logic [ADDR_W-1:0] off_mask;
   logic [DATA_W-1:0] sel_lo;
   logic [DATA_W-1:0] sel_hi;
   logic [OUT_W-1:0]  win_base;
   logic              hit_c;
   logic [OUT_W-1:0]  addr_c;

   always_comb begin
      below    = lk_addr < BASE;
      rel      = lk_addr - BASE;
      shamt    = SH_W'(MB_SHIFT) + SH_W'(win_size);
      win_full = rel >> shamt;
      in_rng   = !below && (win_full < ADDR_W'(NUM_WIN));
      idx      = win_full[IDX_W-1:0];
      off_mask = ~({ADDR_W{1'b1}} << shamt);
      sel_lo   = win_lo[idx];
      sel_hi   = win_hi[idx];
      sel_lo[WIN_VALID_BIT] = 1'b0;
      win_base = {sel_hi, sel_lo};
      hit_c    = xlat_en && in_rng && win_lo[idx][WIN_VALID_BIT];
      addr_c   = win_base + OUT_W'(rel & off_mask);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_hit   <= 1'b0;
         res_addr  <= '0;
      end else begin
         res_valid <= lk_valid;
         res_hit   <= lk_valid && hit_c;
         res_addr  <= (lk_valid && hit_c) ? addr_c : '0;
      end
   end

   // R5
   res_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> res_valid);

   // R5
   res_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> (!res_valid && !res_hit));

   // R7
   xlat_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && !xlat_en) |=> !res_hit);

   // R8
   below_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && lk_addr < BASE) |=> !res_hit);

   // R6
   miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_hit) |-> res_addr == '0);

endmodule

// File: rtl/oat_xlate.sv
module oat_xlate
   import oat_pkg::*;
#(
   parameter int NUM_WIN             = 32,
   parameter int ADDR_W              = 32,
   parameter int DATA_W              = 32,
   parameter int REG_AW              = 12,
   parameter int SIZE_W              = 3,
   parameter int MB_SHIFT            = 20,
   parameter logic [ADDR_W-1:0] BASE = 32'h4000_0000,
   localparam int OUT_W              = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              lk_valid,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic              res_valid,
   output logic              res_hit,
   output logic [OUT_W-1:0]  res_addr
);

   if (NUM_WIN < 1 || (NUM_WIN & (NUM_WIN - 1)) != 0) begin : g_bad_num_win
      $error("NUM_WIN must be a power of two");
   end
   if (MB_SHIFT + (1 << SIZE_W) - 1 >= ADDR_W) begin : g_bad_span
      $error("largest window span exceeds the local address width");
   end
   if (ADDR_W > OUT_W) begin : g_bad_out
      $error("local address wider than translated address");
   end
   if (longint'(WIN_OFS) + longint'(WIN_STRIDE) * NUM_WIN > (longint'(1) << REG_AW)) begin : g_bad_map
      $error("register map does not fit REG_AW");
   end
   if (DATA_W < 2 || SIZE_W > DATA_W) begin : g_bad_data
      $error("DATA_W too small for control and size fields");
   end

   logic                           xlat_en;
   logic [SIZE_W-1:0]              win_size;
   logic [NUM_WIN-1:0][DATA_W-1:0] win_lo;
   logic [NUM_WIN-1:0][DATA_W-1:0] win_hi;

   oat_regs #(
      .NUM_WIN (NUM_WIN),
      .DATA_W  (DATA_W),
      .REG_AW  (REG_AW),
      .SIZE_W  (SIZE_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_wr),
      .rd_en    (reg_rd),
      .reg_addr (reg_addr),
      .wdata    (reg_wdata),
      .rdata    (reg_rdata),
      .xlat_en  (xlat_en),
      .win_size (win_size),
      .win_lo   (win_lo),
      .win_hi   (win_hi)
   );

   oat_lookup #(
      .NUM_WIN  (NUM_WIN),
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .SIZE_W   (SIZE_W),
      .MB_SHIFT (MB_SHIFT),
      .BASE     (BASE)
   ) u_lookup (
      .clk       (clk),
      .rst_n     (rst_n),
      .lk_valid  (lk_valid),
      .lk_addr   (lk_addr),
      .xlat_en   (xlat_en),
      .win_size  (win_size),
      .win_lo    (win_lo),
      .win_hi    (win_hi),
      .res_valid (res_valid),
      .res_hit   (res_hit),
      .res_addr  (res_addr)
   );

endmodule

// File: tb/tb_oat_xlate.sv
`timescale 1ns/1ps
module tb_oat_xlate;

   localparam logic [31:0] BASE = 32'h4000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        lk_valid = 1'b0;
   logic [31:0] lk_addr = '0;
   logic        res_valid, res_hit;
   logic [63:0] res_addr;

   always #4 clk = ~clk;

   oat_xlate dut (
      .clk(clk), .rst_n(rst_n),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .lk_valid(lk_valid), .lk_addr(lk_addr),
      .res_valid(res_valid), .res_hit(res_hit), .res_addr(res_addr)
   );

   // behavioural model state
   logic [31:0] m_lo [32];
   logic [31:0] m_hi [32];
   int          m_size;
   bit          m_en;
   bit          e_valid, e_hit;
   logic [63:0] e_addr;
   logic [31:0] e_rdata;
   int          cyc = 0;
   int          n_chk = 0, n_fail = 0;
   string       cur_req = "R1";
   bit          done = 0;

   function automatic void m_xlate(input logic [31:0] a, output bit h, output logic [63:0] r);
      longint unsigned rel, idx, msk;
      int sh;
      h = 0; r = '0;
      if (a >= BASE) begin
         rel = longint'(a - BASE);
         sh  = 20 + m_size;
         idx = rel >> sh;
         msk = (64'd1 << sh) - 1;
         if (m_en && idx < 32 && m_lo[idx][0]) begin
            h = 1;
            r = {m_hi[idx], m_lo[idx] & 32'hFFFF_FFFE} + (rel & msk);
         end
      end
   endfunction

   function automatic logic [31:0] m_read(input logic [11:0] a);
      int i;
      if (a[1:0] != 0) return '0;
      if (a == 12'h004) return {30'd0, m_en, 1'b0};
      if (a == 12'h030) return 32'(m_size);
      if (a >= 12'h200 && a < 12'h300) begin
         i = int'(a - 12'h200) >> 3;
         return a[2] ? m_hi[i] : m_lo[i];
      end
      return '0;
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         for (int i = 0; i < 32; i++) begin m_lo[i] = '0; m_hi[i] = '0; end
         m_size = 0; m_en = 0;
         e_valid = 0; e_hit = 0; e_addr = '0; e_rdata = '0;
      end else begin
         e_valid = lk_valid;
         if (lk_valid) m_xlate(lk_addr, e_hit, e_addr);
         else begin e_hit = 0; e_addr = '0; end
         e_rdata = reg_rd ? m_read(reg_addr) : '0;
         if (reg_wr && reg_addr[1:0] == 0) begin
            if (reg_addr == 12'h004) m_en = reg_wdata[1];
            else if (reg_addr == 12'h030) m_size = int'(reg_wdata[2:0]);
            else if (reg_addr >= 12'h200 && reg_addr < 12'h300) begin
               if (reg_addr[2]) m_hi[int'(reg_addr - 12'h200) >> 3] = reg_wdata;
               else             m_lo[int'(reg_addr - 12'h200) >> 3] = reg_wdata;
            end
         end
      end
   end

   task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %h expected %h (cycle %0d)", cur_req, what, act, exp, cyc);
      end
   endtask

   always @(negedge clk) begin
      if (cyc >= 2 && !done) begin
         chk("res_valid", 64'(res_valid), 64'(e_valid));
         chk("res_hit",   64'(res_hit),   64'(e_hit));
         chk("res_addr",  res_addr,       e_addr);
         chk("reg_rdata", 64'(reg_rdata), 64'(e_rdata));
      end
   end

   task automatic drv(input bit w, input bit r, input logic [11:0] a,
                      input logic [31:0] d, input bit lv, input logic [31:0] la);
      @(negedge clk);
      reg_wr = w; reg_rd = r; reg_addr = a; reg_wdata = d;
      lk_valid = lv; lk_addr = la;
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d); drv(1, 0, a, d, 0, '0); endtask
   task automatic rd(input logic [11:0] a); drv(0, 1, a, '0, 0, '0); endtask
   task automatic lk(input logic [31:0] la); drv(0, 0, '0, '0, 1, la); endtask
   task automatic idle(); drv(0, 0, '0, '0, 0, '0); endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset contents
      cur_req = "R1";
      rd(12'h004); rd(12'h030); rd(12'h200); rd(12'h2FC);
      lk(32'h4000_0010); idle();
      // R2: register read-back
      cur_req = "R2";
      wr(12'h030, 32'hFFFF_FFFB); rd(12'h030);
      wr(12'h004, 32'hFFFF_FFFD); rd(12'h004);
      wr(12'h004, 32'h0000_0002); rd(12'h004);
      wr(12'h200, 32'h8000_0001); wr(12'h204, 32'h0000_0012);
      wr(12'h208, 32'h9000_0000); wr(12'h20C, 32'h0000_0001);
      wr(12'h228, 32'hA000_0001); wr(12'h22C, 32'hFFFF_FFFF);
      wr(12'h2F8, 32'hFFF0_0001); wr(12'h2FC, 32'h0000_0007);
      rd(12'h200); rd(12'h22C); rd(12'h2F8); rd(12'h2FC);
      // R7: global enable off
      cur_req = "R7";
      wr(12'h004, 32'h0);
      lk(32'h4000_0010); lk(32'h4050_1234); idle();
      wr(12'h004, 32'h2);
      // R3 / R4: size code 0, 1 MB windows
      cur_req = "R4";
      wr(12'h030, 32'h0);
      lk(32'h4000_0010); lk(32'h4050_1234); lk(32'h41F0_ABCD); lk(32'h41FF_FFFF);
      // R6: disabled window
      cur_req = "R6";
      lk(32'h4010_0004); lk(32'h4013_0000); idle();
      // R8: outside the bank
      cur_req = "R8";
      lk(32'h4200_0000); lk(32'h3FFF_FFFF); lk(32'h0000_0000); idle();
      // R3: size code 3, 8 MB windows
      cur_req = "R3";
      wr(12'h030, 32'h3);
      lk(32'h4000_0010); lk(32'h4080_0000); lk(32'h4280_0123); lk(32'h4FFF_FFFF); idle();
      // R3: size code 7, 128 MB windows
      wr(12'h030, 32'h7);
      lk(32'h6800_0040); lk(32'h4000_0000); lk(32'hFFFF_FFFF); lk(32'h6FFF_FFFF); idle();
      // R5: back-to-back lookups and write in the same cycle as a lookup
      cur_req = "R5";
      wr(12'h030, 32'h0);
      drv(1, 0, 12'h200, 32'h8000_0000, 1, 32'h4000_0020);
      lk(32'h4000_0020);
      drv(1, 0, 12'h004, 32'h0, 1, 32'h41F0_0000);
      lk(32'h41F0_0000);
      drv(1, 1, 12'h004, 32'h2, 1, 32'h4050_0000);
      lk(32'h4050_0000); idle();
      // R9: unmapped and unaligned offsets
      cur_req = "R9";
      wr(12'h100, 32'hFFFF_FFFF); wr(12'h031, 32'h7); wr(12'h22A, 32'h1234_5678);
      wr(12'h300, 32'hFFFF_FFFF); wr(12'h000, 32'hFFFF_FFFF);
      rd(12'h030); rd(12'h228); rd(12'h100); rd(12'h22A); rd(12'h300); rd(12'h004);
      lk(32'h4050_0008); idle();
      repeat (3) @(negedge clk);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_fail++;
         $display("FAIL watchdog %s: got hung expected completion", cur_req);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule